// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

This block is a free-running 32-bit up-counter with a compare register. On each cycle where the tick enable is high and counting is not frozen, the count goes up by one. When an increment brings the count onto the compare value, an interrupt becomes pending. The pending request drives exactly one bit of an eight-bit request vector, and a three-bit select input picks which bit. The request stays up until software writes the compare register, which serves as the acknowledge.

A freeze input stops the count without blocking software writes to it. A revision flag decides whether the block also keeps a readable timer-interrupt status bit: with the flag set, a match sets the bit and a compare write clears it; with the flag clear, the bit keeps its value. The tick enable stands for the nominal 100 MHz count rate, one increment per tick.

Top module: `cc_timer`

## Requirements
- R1: After reset the count reads 1, the compare register holds 0, the status bit is 0 and all eight request bits are 0.
- R2: On a cycle with tick_en=1, freeze=0 and cnt_we=0, the count increases by one and wraps from all ones to 0.
- R3: While freeze=1 the count holds its value even with tick_en=1, but a count write still loads the written value.
- R4: A count write on the same cycle as a tick loads the written value and skips the increment.
- R5: When an increment makes the count equal the compare value, the request becomes pending one edge later. irq_o is then 1 at bit index line_sel and 0 elsewhere, and it stays so while the count keeps moving past the compare value.
- R6: A compare write clears the pending request after that edge. With rev2=1 the same write also clears ti_o.
- R7: With rev2=0 the status bit ti_o keeps its value on matches and compare writes, while the request is still raised and cleared as in R5 and R6. With rev2=1 a match sets ti_o.
- R8: No match occurs when the count reaches the compare value by a count write or while freeze=1.
- R9: irq_o has at most one bit set. While a request is pending, changing line_sel moves the request to the newly selected bit at once.
- R10: A compare write on the same cycle as a matching increment leaves no request pending and ti_o cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count tick qualifier |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| cmp_we | input | 1 | Compare write strobe and interrupt acknowledge |
| cmp_wdata | input | 32 | Compare write value |
| freeze | input | 1 | Stops counting and matching while high |
| line_sel | input | 3 | Request line index 0..7 |
| rev2 | input | 1 | Enables the status bit behaviour |
| count_o | output | 32 | Current count |
| ti_o | output | 1 | Timer-interrupt status bit |
| irq_o | output | 8 | Routed interrupt request vector |

## Verification
A count that is corrupted, or that still advances while frozen, shows on count_o at the next edge. A bad compare register shows up only when the count passes the intended value: the request rises at the wrong moment or never rises. The bench therefore places the compare value a few ticks ahead and checks the request on the exact edge. A pending flag that does not get cleared shows on irq_o one edge after the acknowledging write. Wrong routing shows at once as the wrong bit when line_sel changes.

// File: rtl/cct_pkg.sv
package cct_pkg;
    typedef struct packed {
        logic pend;
        logic ti;
    } irq_state_t;

    localparam int RST_COUNT = 1;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         freeze,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_q,
    output logic         inc_fire
);
    logic [W-1:0] count_d;

    always_comb begin
        inc_fire = tick_en && !freeze && !wr_en;
        count_d  = count_q;
        if (wr_en)
            count_d = wr_data;
        else if (inc_fire)
            count_d = count_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= W'(cct_pkg::RST_COUNT);
        else
            count_q <= count_d;
    end
endmodule

// File: rtl/cct_match.sv
module cct_match #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic         inc_fire,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         rev2,
    output logic         pend_o,
    output logic         ti_o
);
    import cct_pkg::*;

    logic [W-1:0] cmp_d, cmp_q;
    irq_state_t   st_d, st_q;
    logic         hit;

    always_comb begin
        hit   = inc_fire && ((count + W'(1)) == cmp_q);
        cmp_d = cmp_we ? cmp_wdata : cmp_q;
        st_d  = st_q;
        if (cmp_we)
            st_d.pend = 1'b0;
        else if (hit)
            st_d.pend = 1'b1;
        if (rev2) begin
            if (cmp_we)
                st_d.ti = 1'b0;
            else if (hit)
                st_d.ti = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            st_q  <= '0;
        end else begin
            cmp_q <= cmp_d;
            st_q  <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign ti_o   = st_q.ti;
endmodule

// File: rtl/cct_route.sv
module cct_route #(
    parameter int LINES = 8,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             pend,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] irq
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign irq[i] = pend && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
    parameter int W = 32,
    parameter int LINES = 8,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_we,
    input  logic [W-1:0]     cnt_wdata,
    input  logic             cmp_we,
    input  logic [W-1:0]     cmp_wdata,
    input  logic             freeze,
    input  logic [SEL_W-1:0] line_sel,
    input  logic             rev2,
    output logic [W-1:0]     count_o,
    output logic             ti_o,
    output logic [LINES-1:0] irq_o
);
    logic inc_fire;
    logic pend;

    cct_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .wr_en(cnt_we), .wr_data(cnt_wdata),
        .count_q(count_o), .inc_fire(inc_fire)
    );

    cct_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .count(count_o), .inc_fire(inc_fire),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .rev2(rev2),
        .pend_o(pend), .ti_o(ti_o)
    );

    cct_route #(.LINES(LINES)) u_route (
        .pend(pend), .sel(line_sel), .irq(irq_o)
    );
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
    parameter int W = 32,
    parameter int LINES = 8,
    localparam int SEL_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cnt_we,
    input logic [W-1:0]     cnt_wdata,
    input logic             cmp_we,
    input logic             freeze,
    input logic             rev2,
    input logic [W-1:0]     count_o,
    input logic             ti_o,
    input logic [LINES-1:0] irq_o
);
    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !cnt_we |=> count_o == $past(count_o));
    // R4
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count_o == $past(cnt_wdata));
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && !freeze && !cnt_we |=> count_o == $past(count_o) + W'(1));
    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> irq_o == '0);
    // R6
    ack_ti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we && rev2 |=> !ti_o);
    // R7
    ti_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rev2 |=> $stable(ti_o));
    // R9
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
endmodule

bind cc_timer cc_timer_chk #(.W(W), .LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .freeze(freeze), .rev2(rev2),
    .count_o(count_o), .ti_o(ti_o), .irq_o(irq_o)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] cnt;
        logic        ti;
        logic [7:0]  irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0, freeze = 1'b0, rev2 = 1'b0;
    logic [31:0] cnt_wdata = '0, cmp_wdata = '0;
    logic [2:0]  line_sel = '0;
    logic [31:0] count_o;
    logic        ti_o;
    logic [7:0]  irq_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    logic [31:0] m_cnt, m_cmp;
    logic        m_pend, m_ti;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_timer u_cc_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .freeze(freeze), .line_sel(line_sel), .rev2(rev2),
        .count_o(count_o), .ti_o(ti_o), .irq_o(irq_o)
    );

    task automatic step(input logic tk, input logic cw, input logic [31:0] cwd,
                        input logic pw, input logic [31:0] pwd, input logic frz,
                        input logic [2:0] sel, input logic r2, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        tick_en = tk; cnt_we = cw; cnt_wdata = cwd; cmp_we = pw; cmp_wdata = pwd;
        freeze = frz; line_sel = sel; rev2 = r2;
        hit = tk && !frz && !cw && (m_cnt + 32'd1 == m_cmp);
        if (cw) m_cnt = cwd;
        else if (tk && !frz) m_cnt = m_cnt + 32'd1;
        m_pend = pw ? 1'b0 : (m_pend | hit);
        if (r2) m_ti = pw ? 1'b0 : (m_ti | hit);
        if (pw) m_cmp = pwd;
        e.cnt = m_cnt; e.ti = m_ti;
        e.irq = m_pend ? (8'd1 << sel) : 8'd0;
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (count_o !== e.cnt || ti_o !== e.ti || irq_o !== e.irq) begin
                fails++;
                $display("FAIL %s: actual cnt=%h ti=%b irq=%b expected cnt=%h ti=%b irq=%b",
                         e.tag, count_o, ti_o, irq_o, e.cnt, e.ti, e.irq);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_cnt = 32'd1; m_cmp = 32'd0; m_pend = 1'b0; m_ti = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (count_o !== 32'd1 || ti_o !== 1'b0 || irq_o !== 8'd0) begin
            fails++;
            $display("FAIL R1 reset: actual cnt=%h ti=%b irq=%b expected cnt=1 ti=0 irq=0",
                     count_o, ti_o, irq_o);
        end
        // R2 plain counting, and idle without tick
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 3'd0, 1, "R2 count");
        step(0, 0, 0, 0, 0, 0, 3'd0, 1, "R2 no tick");
        // R3 frozen count, write still lands
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1, 3'd0, 1, "R3 frozen");
        step(1, 1, 32'd100, 0, 0, 1, 3'd0, 1, "R3 write while frozen");
        // R4 write beats tick
        step(1, 1, 32'd105, 0, 0, 0, 3'd0, 1, "R4 write over tick");
        // R5 match at 110 on line 3, rev2 set
        step(0, 0, 0, 1, 32'd110, 0, 3'd3, 1, "R5 set compare");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 3'd3, 1, "R5 approach and pass");
        // R9 rerouting while pending
        step(1, 0, 0, 0, 0, 0, 3'd7, 1, "R9 move to 7");
        step(0, 0, 0, 0, 0, 0, 3'd0, 1, "R9 move to 0");
        // R7 ack with rev2 clear keeps ti
        step(0, 0, 0, 1, 32'd200, 0, 3'd0, 0, "R7 ack keeps ti");
        // R7 match with rev2 clear: line rises, ti unchanged
        step(0, 1, 32'd197, 0, 0, 0, 3'd5, 0, "R7 set count");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 3'd5, 0, "R7 match no ti change");
        // R6 ack with rev2 set clears ti and line
        step(0, 0, 0, 1, 32'd300, 0, 3'd5, 1, "R6 ack clears");
        // R8 count write onto compare value: no match
        step(0, 1, 32'd300, 0, 0, 0, 3'd1, 1, "R8 write onto compare");
        step(1, 0, 0, 0, 0, 0, 3'd1, 1, "R8 after write");
        // R8 frozen right before compare: no match
        step(0, 1, 32'd309, 0, 0, 0, 3'd1, 1, "R8 set near");
        step(0, 0, 0, 1, 32'd310, 0, 3'd1, 1, "R8 compare 310");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1, 3'd1, 1, "R8 frozen no match");
        // R10 compare write on matching increment
        step(1, 0, 0, 1, 32'd500, 0, 3'd1, 1, "R10 ack same cycle");
        step(0, 0, 0, 0, 0, 0, 3'd1, 1, "R10 stays clear");
        // R2/R5 wrap: compare 0 reached from all ones
        step(0, 1, 32'hFFFF_FFFE, 1, 32'd0, 0, 3'd2, 1, "R2 set near wrap");
        step(1, 0, 0, 0, 0, 0, 3'd2, 1, "R2 to all ones");
        step(1, 0, 0, 0, 0, 0, 3'd2, 1, "R5 wrap match");
        step(1, 0, 0, 0, 0, 0, 3'd2, 1, "R5 held after wrap");
        step(0, 0, 0, 0, 0, 0, 3'd2, 1, "R9 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule